// File: doc/BRIEF.md
# Keyboard Controller Command Sequencer

This block runs one command against a byte-wide keyboard controller register interface on behalf of a host engine. A 16-bit command word carries the command byte in its low half and, in its upper nibbles, how many parameter bytes follow it and how many response bytes come back. The block writes the command byte, then the parameter bytes taken from a small buffer, then reads the response bytes back into that same buffer. Before every access it polls the controller status byte until the relevant flag says the access may proceed.

Every wait is bounded by a poll limit. When it runs out, the command ends with a timeout error. One command word, the auxiliary loopback command, gets an extra check: each response must carry the auxiliary-data status flag, or the command ends with a port-mismatch error. A separate input can disable that loopback command outright, so that it fails at once without touching the bus.

The register bus is a single-cycle strobe. `bus_op` selects a status read, data read, command write or data write. The controller model drives `bus_rdata` combinationally during the strobe cycle, and the block samples it at the clock edge that closes that cycle.

Top module: `kbc_cmd_sequencer`

## Requirements
- R1: After reset `busy`, `done`, `err` and `bus_stb` are all low, and the block waits for `start`.
- R2: The first write of a command is a command-register write (`bus_op`=2) of bits 7:0 of `cmd_word`. It is issued in the cycle after a status read (`bus_op`=0) that returned status bit 1 (input full) clear. Status bits other than 0, 1 and 5 have no effect.
- R3: Bits 15:12 of `cmd_word` give the number of parameter bytes, 0 to 15. They are written as data-register writes (`bus_op`=3) in buffer order from entry 0. Each is issued in the cycle after a status read with bit 1 clear.
- R4: Bits 11:8 give the number of response bytes, 0 to 15. Each data read (`bus_op`=1) comes in the cycle after a status read with bit 0 (output full) set. Response k overwrites buffer entry k, and higher entries keep the values loaded at start.
- R5: If one wait sees POLL_LIMIT consecutive status reads without its flag, the command ends with `err` and `err_code`=1, and no further bus access follows. A wait that succeeds on poll POLL_LIMIT completes normally.
- R6: For the loopback word (`LOOP_WORD`, default 16'h11D3), a response status with bit 0 set and bit 5 (auxiliary data) clear ends the command with `err_code`=2, and that byte is not read. When bit 5 is set, the byte is read normally. Other commands ignore bit 5.
- R7: With `loop_off` high, starting the loopback word raises `err` with `err_code`=3 in the next cycle, with no bus access and no buffer reload. `loop_off` has no effect on any other word.
- R8: `busy` is high from the cycle after an accepted `start` until the final pulse. `done` or `err` is high for exactly one cycle, and `busy` is low in that cycle. A `start` while busy is ignored.
- R9: A word with both counts zero ends with `done` in the cycle after its command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command, accepted only when idle |
| cmd_word | input | 16 | Command byte and the two counts |
| loop_off | input | 1 | Refuse the loopback command |
| param_in | input | BUF_DEPTH*8 | Buffer contents loaded at start, entry k at bits 8k+7:8k |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse on success |
| err | output | 1 | One-cycle pulse on failure |
| err_code | output | 2 | 1 timeout, 2 port mismatch, 3 refused; valid with `err` |
| param_out | output | BUF_DEPTH*8 | Buffer contents, responses included |
| bus_stb | output | 1 | Register access this cycle |
| bus_op | output | 2 | 0 status read, 1 data read, 2 command write, 3 data write |
| bus_wdata | output | 8 | Write byte |
| bus_rdata | input | 8 | Read byte, valid during the strobe cycle |

## Verification
The assertions assume that `bus_rdata` is a settled, known value whenever `bus_stb` is high, since it is sampled at the closing edge of each strobe. They also assume that `cmd_word` and `loop_off` are stable in any cycle where `start` is high. The bench changes `bus_rdata`, `start` and the command inputs only at falling edges. It serves each status and data value from the same per-cycle expected trace that it checks the block's accesses against, so the controller model never presents a byte that belongs to a different access.

// File: rtl/kbc_seq_pkg.sv
package kbc_seq_pkg;

   localparam int CNT_W  = 4;
   localparam int ST_OBF = 0;
   localparam int ST_IBF = 1;
   localparam int ST_AUX = 5;

   typedef enum logic [1:0] {
      OP_STAT = 2'd0,
      OP_RDAT = 2'd1,
      OP_WCMD = 2'd2,
      OP_WDAT = 2'd3
   } bus_op_t;

   typedef enum logic [1:0] {
      ERR_NONE    = 2'd0,
      ERR_TIMEOUT = 2'd1,
      ERR_PORT    = 2'd2,
      ERR_OFF     = 2'd3
   } err_code_t;

   typedef enum logic [2:0] {
      S_IDLE,
      S_POLL_IN,
      S_WR_CMD,
      S_WR_PAR,
      S_POLL_OUT,
      S_RD
   } seq_state_t;

endpackage

// File: rtl/kbc_poll_timer.sv
module kbc_poll_timer #(
   parameter int unsigned POLL_LIMIT = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic expired
);
   localparam int unsigned CW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;

   generate
      if (POLL_LIMIT == 1) begin : g_single
         logic unused_single;
         assign unused_single = ^{clk, rst_n, clr};
         assign expired = tick;
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt <= '0;
            else if (clr)  cnt <= '0;
            else if (tick) cnt <= cnt + 1'b1;
         end
         assign expired = tick && (cnt == CW'(POLL_LIMIT - 1));
      end
   endgenerate

endmodule

// File: rtl/kbc_param_buf.sv
module kbc_param_buf #(
   parameter int DEPTH = 16,
   parameter int IDX_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [DEPTH*8-1:0] load_data,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [7:0]         wr_data,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [7:0]         rd_data,
   output logic [DEPTH*8-1:0] contents
);

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_ent
         logic [7:0] ent;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ent <= 8'h00;
            else if (load)
               ent <= load_data[g*8 +: 8];
            else if (wr_en && (wr_idx == IDX_W'(g)))
               ent <= wr_data;
         end
         assign contents[g*8 +: 8] = ent;
      end
   endgenerate

   assign rd_data = contents[rd_idx*8 +: 8];

endmodule

// File: rtl/kbc_seq_fsm.sv
module kbc_seq_fsm
   import kbc_seq_pkg::*;
#(
   parameter logic [15:0] LOOP_WORD = 16'h11D3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [15:0]      cmd_word,
   input  logic             loop_off,
   input  logic [7:0]       bus_rdata,
   input  logic [7:0]       par_byte,
   input  logic             poll_expired,
   output logic             busy,
   output logic             done,
   output logic             err,
   output logic [1:0]       err_code,
   output logic             bus_stb,
   output logic [1:0]       bus_op,
   output logic [7:0]       bus_wdata,
   output logic             poll_tick,
   output logic             poll_clr,
   output logic             buf_load,
   output logic             buf_wr,
   output logic [CNT_W-1:0] par_idx,
   output logic [CNT_W-1:0] rsp_idx
);

   seq_state_t      state;
   logic [7:0]      cmd_lo;
   logic [CNT_W-1:0] n_par, n_rsp, pidx, ridx;
   logic            cmd_sent, is_loop, done_q, err_q;
   err_code_t       code_q;

   logic ibf, obf, aux, refuse, par_last, rsp_last;
   logic unused_status_bits;

   assign ibf = bus_rdata[ST_IBF];
   assign obf = bus_rdata[ST_OBF];
   assign aux = bus_rdata[ST_AUX];
   assign unused_status_bits = ^{bus_rdata[7:6], bus_rdata[4:2]};

   assign refuse   = start && loop_off && (cmd_word == LOOP_WORD);
   assign par_last = ((CNT_W+1)'(pidx) + 1'b1) >= (CNT_W+1)'(n_par);
   assign rsp_last = ((CNT_W+1)'(ridx) + 1'b1) >= (CNT_W+1)'(n_rsp);

   always_comb begin
      bus_stb   = 1'b0;
      bus_op    = OP_STAT;
      bus_wdata = 8'h00;
      case (state)
         S_POLL_IN, S_POLL_OUT: begin bus_stb = 1'b1; bus_op = OP_STAT; end
         S_WR_CMD: begin bus_stb = 1'b1; bus_op = OP_WCMD; bus_wdata = cmd_lo; end
         S_WR_PAR: begin bus_stb = 1'b1; bus_op = OP_WDAT; bus_wdata = par_byte; end
         S_RD:     begin bus_stb = 1'b1; bus_op = OP_RDAT; end
         default:  ;
      endcase
   end

   assign poll_tick = ((state == S_POLL_IN) && ibf) || ((state == S_POLL_OUT) && !obf);
   assign poll_clr  = (state == S_IDLE) || ((state == S_POLL_IN) && !ibf) ||
                      ((state == S_POLL_OUT) && obf);
   assign buf_load  = (state == S_IDLE) && start && !refuse;
   assign buf_wr    = (state == S_RD);
   assign par_idx   = pidx;
   assign rsp_idx   = ridx;
   assign busy      = (state != S_IDLE);
   assign done      = done_q;
   assign err       = err_q;
   assign err_code  = code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         cmd_lo   <= 8'h00;
         n_par    <= '0;
         n_rsp    <= '0;
         pidx     <= '0;
         ridx     <= '0;
         cmd_sent <= 1'b0;
         is_loop  <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         code_q   <= ERR_NONE;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (state)
            S_IDLE: begin
               if (refuse) begin
                  err_q  <= 1'b1;
                  code_q <= ERR_OFF;
               end else if (start) begin
                  cmd_lo   <= cmd_word[7:0];
                  n_par    <= cmd_word[15:12];
                  n_rsp    <= cmd_word[11:8];
                  is_loop  <= (cmd_word == LOOP_WORD);
                  pidx     <= '0;
                  ridx     <= '0;
                  cmd_sent <= 1'b0;
                  state    <= S_POLL_IN;
               end
            end
            S_POLL_IN: begin
               if (poll_expired) begin
                  err_q  <= 1'b1;
                  code_q <= ERR_TIMEOUT;
                  state  <= S_IDLE;
               end else if (!ibf) begin
                  state <= cmd_sent ? S_WR_PAR : S_WR_CMD;
               end
            end
            S_WR_CMD: begin
               cmd_sent <= 1'b1;
               if (n_par != '0)
                  state <= S_POLL_IN;
               else if (n_rsp != '0)
                  state <= S_POLL_OUT;
               else begin
                  done_q <= 1'b1;
                  code_q <= ERR_NONE;
                  state  <= S_IDLE;
               end
            end
            S_WR_PAR: begin
               pidx <= pidx + 1'b1;
               if (!par_last)
                  state <= S_POLL_IN;
               else if (n_rsp != '0)
                  state <= S_POLL_OUT;
               else begin
                  done_q <= 1'b1;
                  code_q <= ERR_NONE;
                  state  <= S_IDLE;
               end
            end
            S_POLL_OUT: begin
               if (poll_expired) begin
                  err_q  <= 1'b1;
                  code_q <= ERR_TIMEOUT;
                  state  <= S_IDLE;
               end else if (obf) begin
                  if (is_loop && !aux) begin
                     err_q  <= 1'b1;
                     code_q <= ERR_PORT;
                     state  <= S_IDLE;
                  end else begin
                     state <= S_RD;
                  end
               end
            end
            S_RD: begin
               ridx <= ridx + 1'b1;
               if (!rsp_last)
                  state <= S_POLL_OUT;
               else begin
                  done_q <= 1'b1;
                  code_q <= ERR_NONE;
                  state  <= S_IDLE;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assert_cmd_after_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_stb && bus_op == OP_WCMD) |->
      $past(bus_stb && bus_op == OP_STAT && !bus_rdata[ST_IBF]));

   assert_par_after_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_stb && bus_op == OP_WDAT) |->
      $past(bus_stb && bus_op == OP_STAT && !bus_rdata[ST_IBF]));

   assert_read_after_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_stb && bus_op == OP_RDAT) |->
      $past(bus_stb && bus_op == OP_STAT && bus_rdata[ST_OBF]));

   assert_timeout_on_poll_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (err && err_code == ERR_TIMEOUT) |-> $past(bus_stb && bus_op == OP_STAT));

   assert_port_mismatch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (err && err_code == ERR_PORT) |->
      $past(bus_stb && bus_op == OP_STAT && bus_rdata[ST_OBF] && !bus_rdata[ST_AUX]));

   assert_refuse_no_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (err && err_code == ERR_OFF) |-> $past(!bus_stb && start));

   assert_single_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, err}));

   assert_idle_at_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |-> (!busy && !bus_stb));

endmodule

// File: rtl/kbc_cmd_sequencer.sv
module kbc_cmd_sequencer
   import kbc_seq_pkg::*;
#(
   parameter int unsigned  BUF_DEPTH  = 16,
   parameter int unsigned  POLL_LIMIT = 10000,
   parameter logic [15:0]  LOOP_WORD  = 16'h11D3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [15:0]            cmd_word,
   input  logic                   loop_off,
   input  logic [BUF_DEPTH*8-1:0] param_in,
   output logic                   busy,
   output logic                   done,
   output logic                   err,
   output logic [1:0]             err_code,
   output logic [BUF_DEPTH*8-1:0] param_out,
   output logic                   bus_stb,
   output logic [1:0]             bus_op,
   output logic [7:0]             bus_wdata,
   input  logic [7:0]             bus_rdata
);
   localparam int IDX_W = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;

   generate
      if (BUF_DEPTH < (2**CNT_W) - 1) begin : g_bad_depth
         $error("BUF_DEPTH must hold the largest count carried by the command word");
      end
      if (POLL_LIMIT < 1) begin : g_bad_limit
         $error("POLL_LIMIT must be at least one poll");
      end
   endgenerate

   logic             poll_tick, poll_clr, poll_expired;
   logic             buf_load, buf_wr;
   logic [CNT_W-1:0] par_idx, rsp_idx;
   logic [7:0]       par_byte;

   kbc_seq_fsm #(
      .LOOP_WORD (LOOP_WORD)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .cmd_word     (cmd_word),
      .loop_off     (loop_off),
      .bus_rdata    (bus_rdata),
      .par_byte     (par_byte),
      .poll_expired (poll_expired),
      .busy         (busy),
      .done         (done),
      .err          (err),
      .err_code     (err_code),
      .bus_stb      (bus_stb),
      .bus_op       (bus_op),
      .bus_wdata    (bus_wdata),
      .poll_tick    (poll_tick),
      .poll_clr     (poll_clr),
      .buf_load     (buf_load),
      .buf_wr       (buf_wr),
      .par_idx      (par_idx),
      .rsp_idx      (rsp_idx)
   );

   kbc_poll_timer #(
      .POLL_LIMIT (POLL_LIMIT)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (poll_clr),
      .tick    (poll_tick),
      .expired (poll_expired)
   );

   kbc_param_buf #(
      .DEPTH (BUF_DEPTH),
      .IDX_W (IDX_W)
   ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (buf_load),
      .load_data (param_in),
      .wr_en     (buf_wr),
      .wr_idx    (IDX_W'(rsp_idx)),
      .wr_data   (bus_rdata),
      .rd_idx    (IDX_W'(par_idx)),
      .rd_data   (par_byte),
      .contents  (param_out)
   );

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!busy && !bus_stb && !done && !err));

endmodule

// File: tb/test_kbc_cmd_sequencer.sv
module test_kbc_cmd_sequencer;
   import kbc_seq_pkg::*;

   localparam int DEPTH = 16;
   localparam int LIMIT = 12;

   typedef struct {
      logic [1:0] op;
      logic [7:0] wd;
      logic [7:0] rd;
   } acc_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [15:0]      cmd_word = 16'h0000;
   logic             loop_off = 1'b0;
   logic [DEPTH*8-1:0] param_in = '0;
   logic             busy, done, err;
   logic [1:0]       err_code;
   logic [DEPTH*8-1:0] param_out;
   logic             bus_stb;
   logic [1:0]       bus_op;
   logic [7:0]       bus_wdata;
   logic [7:0]       bus_rdata = 8'h00;

   int   checks = 0;
   int   errors = 0;
   int   cycles = 0;
   acc_t trace[$];
   logic [7:0] exp_buf [DEPTH];
   int   inject_at = -1;
   logic [15:0] inject_word = 16'h0000;

   always #10 clk = ~clk;

   kbc_cmd_sequencer #(
      .BUF_DEPTH  (DEPTH),
      .POLL_LIMIT (LIMIT),
      .LOOP_WORD  (16'h11D3)
   ) i_kbc_cmd_sequencer (
      .clk (clk), .rst_n (rst_n), .start (start), .cmd_word (cmd_word),
      .loop_off (loop_off), .param_in (param_in), .busy (busy), .done (done),
      .err (err), .err_code (err_code), .param_out (param_out),
      .bus_stb (bus_stb), .bus_op (bus_op), .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic acc_t mk(input logic [1:0] op, input logic [7:0] wd,
                               input logic [7:0] rd);
      acc_t a;
      a.op = op; a.wd = wd; a.rd = rd;
      return a;
   endfunction

   // busy polls show input full plus a noise bit; the free poll shows only noise bits
   task automatic push_write(input int busy_polls, input logic [1:0] op, input logic [7:0] wd);
      for (int k = 0; k < busy_polls; k++) trace.push_back(mk(OP_STAT, 8'h00, 8'h06));
      trace.push_back(mk(OP_STAT, 8'h00, 8'hC4));
      trace.push_back(mk(op, wd, 8'h00));
   endtask

   task automatic push_resp(input int wait_polls, input logic [7:0] st, input logic [7:0] data);
      for (int k = 0; k < wait_polls; k++) trace.push_back(mk(OP_STAT, 8'h00, 8'h22));
      trace.push_back(mk(OP_STAT, 8'h00, st));
      trace.push_back(mk(OP_RDAT, 8'h00, data));
   endtask

   task automatic set_params(input logic [7:0] seed);
      for (int k = 0; k < DEPTH; k++) begin
         exp_buf[k] = seed + 8'(k * 7);
         param_in[k*8 +: 8] = exp_buf[k];
      end
   endtask

   task automatic run_cmd(input logic [15:0] word, input bit off, input bit exp_err,
                          input logic [1:0] exp_code, input string req);
      int   i;
      acc_t a;
      cmd_word = word;
      loop_off = off;
      start    = 1'b1;
      i        = 0;
      @(negedge clk);
      while (trace.size() > 0) begin
         start = (i == inject_at);
         if (start) cmd_word = inject_word;
         a = trace.pop_front();
         chk(bus_stb === 1'b1 && bus_op === a.op, req, "bus access",
             {bus_stb, bus_op}, {1'b1, a.op});
         if (a.op == OP_WCMD || a.op == OP_WDAT)
            chk(bus_wdata === a.wd, req, "write byte", bus_wdata, a.wd);
         chk(busy === 1'b1 && done === 1'b0 && err === 1'b0, "R8", "busy during command",
             {busy, done, err}, 3'b100);
         bus_rdata = a.rd;
         i++;
         @(negedge clk);
      end
      start     = 1'b0;
      bus_rdata = 8'h00;
      chk(done === !exp_err && err === exp_err, req, "outcome pulse",
          {done, err}, {!exp_err, exp_err});
      if (exp_err) chk(err_code === exp_code, req, "error code", err_code, exp_code);
      chk(busy === 1'b0 && bus_stb === 1'b0, "R8", "idle at outcome", {busy, bus_stb}, 0);
      @(negedge clk);
      chk(done === 1'b0 && err === 1'b0, "R8", "outcome lasts one cycle", {done, err}, 0);
      chk(bus_stb === 1'b0, req, "no access after end", bus_stb, 0);
      for (int k = 0; k < DEPTH; k++)
         chk(param_out[k*8 +: 8] === exp_buf[k], req, "buffer entry",
             param_out[k*8 +: 8], exp_buf[k]);
      inject_at = -1;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      set_params(8'h10);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy === 1'b0 && done === 1'b0 && err === 1'b0 && bus_stb === 1'b0, "R1",
          "reset outputs", {busy, done, err, bus_stb}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy === 1'b0 && bus_stb === 1'b0, "R1", "idle after reset", {busy, bus_stb}, 0);

      // R9 and R2: no parameters, no responses
      push_write(1, OP_WCMD, 8'h60);
      run_cmd(16'h0060, 1'b0, 1'b0, 2'd0, "R9");

      // R3: one parameter after two busy polls
      set_params(8'h31);
      push_write(0, OP_WCMD, 8'h60);
      push_write(2, OP_WDAT, exp_buf[0]);
      run_cmd(16'h1060, 1'b0, 1'b0, 2'd0, "R3");

      // R4: one response, no aux flag on a normal command
      set_params(8'h52);
      push_write(0, OP_WCMD, 8'h20);
      push_resp(3, 8'h01, 8'h47);
      exp_buf[0] = 8'h47;
      run_cmd(16'h0120, 1'b0, 1'b0, 2'd0, "R4");

      // R3 and R4 mixed: three parameters, two responses
      set_params(8'h77);
      push_write(1, OP_WCMD, 8'h55);
      for (int p = 0; p < 3; p++) push_write(p, OP_WDAT, exp_buf[p]);
      push_resp(0, 8'h01, 8'h9C);
      push_resp(2, 8'hE1, 8'h3D);
      exp_buf[0] = 8'h9C;
      exp_buf[1] = 8'h3D;
      run_cmd(16'h3255, 1'b0, 1'b0, 2'd0, "R4");

      // R3 boundary: fifteen parameters
      set_params(8'h05);
      push_write(0, OP_WCMD, 8'hAA);
      for (int p = 0; p < 15; p++) push_write(p % 3, OP_WDAT, exp_buf[p]);
      run_cmd(16'hF0AA, 1'b0, 1'b0, 2'd0, "R3");

      // R4 boundary: fifteen responses
      set_params(8'h90);
      push_write(0, OP_WCMD, 8'h20);
      for (int r = 0; r < 15; r++) begin
         push_resp(r % 2, 8'h01, 8'(8'hC0 + r));
         exp_buf[r] = 8'(8'hC0 + r);
      end
      run_cmd(16'h0F20, 1'b0, 1'b0, 2'd0, "R4");

      // R5: input-full never clears
      set_params(8'h21);
      for (int k = 0; k < LIMIT; k++) trace.push_back(mk(OP_STAT, 8'h00, 8'h06));
      run_cmd(16'h0060, 1'b0, 1'b1, 2'd1, "R5");

      // R5 boundary: success on the last allowed poll
      push_write(LIMIT - 1, OP_WCMD, 8'h60);
      run_cmd(16'h0060, 1'b0, 1'b0, 2'd0, "R5");

      // R5: output-full never sets
      push_write(0, OP_WCMD, 8'h20);
      for (int k = 0; k < LIMIT; k++) trace.push_back(mk(OP_STAT, 8'h00, 8'h22));
      run_cmd(16'h0120, 1'b0, 1'b1, 2'd1, "R5");

      // R6: loopback with aux flag set
      set_params(8'h5A);
      push_write(0, OP_WCMD, 8'hD3);
      push_write(1, OP_WDAT, 8'h5A);
      push_resp(1, 8'h21, 8'h5A);
      run_cmd(16'h11D3, 1'b0, 1'b0, 2'd0, "R6");

      // R6: loopback response without aux flag, byte left unread
      set_params(8'h6B);
      push_write(0, OP_WCMD, 8'hD3);
      push_write(0, OP_WDAT, exp_buf[0]);
      trace.push_back(mk(OP_STAT, 8'h00, 8'h01));
      run_cmd(16'h11D3, 1'b0, 1'b1, 2'd2, "R6");

      // R7: loopback refused, no bus access, buffer keeps prior contents
      param_in = '1;
      run_cmd(16'h11D3, 1'b1, 1'b1, 2'd3, "R7");

      // R7: refusal input has no effect on another word
      set_params(8'h44);
      push_write(0, OP_WCMD, 8'h20);
      push_resp(0, 8'h01, 8'hE7);
      exp_buf[0] = 8'hE7;
      run_cmd(16'h0120, 1'b1, 1'b0, 2'd0, "R7");

      // R8: start while busy is ignored
      set_params(8'h13);
      push_write(0, OP_WCMD, 8'h60);
      push_write(0, OP_WDAT, exp_buf[0]);
      push_write(1, OP_WDAT, exp_buf[1]);
      inject_at   = 2;
      inject_word = 16'h0F11;
      run_cmd(16'h2060, 1'b0, 1'b0, 2'd0, "R8");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule